// File: doc/BRIEF.md
# Stereo Cross-Mix Gain Matrix

This block mixes a decoded stereo sample pair through a 2×2 gain matrix. The left result is the left input scaled by the left-to-left gain plus the right input scaled by the right-to-left gain. The right result is the left input scaled by the left-to-right gain plus the right input scaled by the right-to-right gain. Each of the four gains is chosen by an 8-bit code on a logarithmic scale. The scale has a fine segment, a coarse segment and a mute code. The same datapath therefore gives per-channel volume, channel swap, mono fold-down or a controlled amount of crosstalk.

Gain codes arrive one at a time on a write strobe. They always go in the fixed order left-to-left, left-to-right, right-to-left, right-to-left-to-right last (right-to-right), and the order then wraps. Clicks are avoided by keeping, for each coefficient, an effective code that moves one code step per sample toward the code last written. The first step is applied to the very next sample. The matrix does not guard against overflow. The sum is saturated to the sample width, so that an overflowing mix gives a defined result.

Top module: `xmix_matrix`

## Requirements
- R1: Codes 0 to 64 fall by 3/16 dB per step. The gain in Q1.15 is round(32768·2^(-m/32)) >> s, with m = code mod 32 and s = code div 32. Code 0 is 32768 (unity), code 16 is 23170, code 32 is 16384 and code 64 is 8192.
- R2: Codes 65 to 254 fall by 3/8 dB per step. With j = code − 64, the shift is 2 + j div 16 and m = 2·(j mod 16). Code 65 is 7844, code 80 is 4096 and code 254 is 2.
- R3: Code 255 is mute (gain 0). When all four coefficients are muted, both outputs are 0.
- R4: Successive writes load coefficient slots in the order left-to-left (0), left-to-right (1), right-to-left (2), right-to-right (3). The slot pointer wraps to 0 after slot 3, and reset puts it at slot 0.
- R5: Each coefficient's effective code moves exactly one step toward its target on every sample strobe. The stepped code is the one applied to that same sample, so a new target affects the first sample after the write.
- R6: out_l = floor((in_l·g0 + in_r·g2) / 32768) and out_r = floor((in_l·g1 + in_r·g3) / 32768), where gk is the Q1.15 gain of slot k.
- R7: A result above 2^(W−1)−1 or below −2^(W−1) is clamped to that limit.
- R8: out_valid is high for exactly the cycle after a cycle with sample_valid high. out_l and out_r change only in that cycle and hold otherwise.
- R9: After reset the targets and effective codes are 0, 255, 255, 0 (identity pass-through). out_l, out_r and out_valid are 0.
- R10: The effective codes do not move in cycles without a sample strobe, however long the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe: a stereo pair is present on in_l / in_r |
| in_l | input | W | Left input sample, two's complement |
| in_r | input | W | Right input sample, two's complement |
| coef_wr | input | 1 | Write strobe for the next coefficient slot |
| coef_idx | input | 8 | Gain code written with coef_wr |
| out_valid | output | 1 | Mixed pair is present on out_l / out_r |
| out_l | output | W | Left mixed sample |
| out_r | output | W | Right mixed sample |

## Verification
The assertions take for granted that sample_valid and coef_wr are single-cycle strobes sampled at the clock edge. They also assume that inputs are stable around that edge and that at least one idle cycle separates two sample strobes. The bench drives every input on the falling edge and deasserts each strobe one cycle later. Before each gain is measured, it runs enough sample periods for every ramp to finish. It reads a gain directly by feeding the most negative sample into a single path, so the output equals the negated gain.

// File: rtl/xmix_pkg.sv
package xmix_pkg;
  localparam int NUM_COEF   = 4;
  localparam int CODE_W     = 8;
  localparam int GAIN_W     = 16;
  localparam int GAIN_FRAC  = 15;
  localparam int SLOT_LL    = 0;
  localparam int SLOT_LR    = 1;
  localparam int SLOT_RL    = 2;
  localparam int SLOT_RR    = 3;
  localparam logic [CODE_W-1:0] CODE_MUTE = 8'hFF;

  // reset code per slot: straight paths unity, cross paths muted
  function automatic logic [CODE_W-1:0] reset_code(input int slot);
    return (slot == SLOT_LL || slot == SLOT_RR) ? 8'd0 : CODE_MUTE;
  endfunction

  // 2^(-m/32) in Q1.15, one octave of mantissas
  function automatic logic [GAIN_W-1:0] mant(input logic [4:0] m);
    case (m)
      5'd0:  return 16'd32768;  5'd1:  return 16'd32066;
      5'd2:  return 16'd31379;  5'd3:  return 16'd30706;
      5'd4:  return 16'd30048;  5'd5:  return 16'd29405;
      5'd6:  return 16'd28774;  5'd7:  return 16'd28158;
      5'd8:  return 16'd27554;  5'd9:  return 16'd26964;
      5'd10: return 16'd26386;  5'd11: return 16'd25821;
      5'd12: return 16'd25268;  5'd13: return 16'd24726;
      5'd14: return 16'd24196;  5'd15: return 16'd23678;
      5'd16: return 16'd23170;  5'd17: return 16'd22674;
      5'd18: return 16'd22188;  5'd19: return 16'd21713;
      5'd20: return 16'd21248;  5'd21: return 16'd20792;
      5'd22: return 16'd20347;  5'd23: return 16'd19911;
      5'd24: return 16'd19484;  5'd25: return 16'd19066;
      5'd26: return 16'd18658;  5'd27: return 16'd18258;
      5'd28: return 16'd17867;  5'd29: return 16'd17484;
      5'd30: return 16'd17109;  default: return 16'd16743;
    endcase
  endfunction
endpackage

// File: rtl/xmix_gain_lut.sv
module xmix_gain_lut
  import xmix_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [GAIN_W-1:0] gain
);
  logic [CODE_W-1:0] rel;
  logic [4:0]        m;
  logic [3:0]        sh;

  always_comb begin
    rel = code - 8'd64;
    if (code <= 8'd64) begin
      // fine segment: 32 codes per octave
      m  = code[4:0];
      sh = {2'b00, code[6:5]};
    end else begin
      // coarse segment: 16 codes per octave
      m  = {rel[3:0], 1'b0};
      sh = 4'd2 + rel[7:4];
    end
    gain = (code == CODE_MUTE) ? '0 : (mant(m) >> sh);
  end
endmodule

// File: rtl/xmix_coef_ramp.sv
module xmix_coef_ramp
  import xmix_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              step_en,
  output logic [CODE_W-1:0] tgt,
  output logic [CODE_W-1:0] cur,
  output logic [CODE_W-1:0] nxt
);
  logic [CODE_W-1:0] tgt_d;
  logic [CODE_W-1:0] cur_d;

  always_comb begin
    if (cur < tgt)      nxt = cur + 8'd1;
    else if (cur > tgt) nxt = cur - 8'd1;
    else                nxt = cur;
    tgt_d = wr_en   ? wr_code : tgt;
    cur_d = step_en ? nxt     : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt <= RST_CODE;
      cur <= RST_CODE;
    end else begin
      tgt <= tgt_d;
      cur <= cur_d;
    end
  end
endmodule

// File: rtl/xmix_mix_chan.sv
module xmix_mix_chan
  import xmix_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic [GAIN_W-1:0]   ga,
  input  logic [GAIN_W-1:0]   gb,
  output logic signed [W-1:0] y
);
  localparam int PRD_W = W + GAIN_W + 1;
  localparam int SUM_W = PRD_W + 1;
  localparam logic signed [SUM_W-1:0] HI = {{(SUM_W-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO = {{(SUM_W-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [PRD_W-1:0] pa;
  logic signed [PRD_W-1:0] pb;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] scaled;

  always_comb begin
    pa     = a * $signed({1'b0, ga});
    pb     = b * $signed({1'b0, gb});
    sum    = {pa[PRD_W-1], pa} + {pb[PRD_W-1], pb};
    scaled = sum >>> GAIN_FRAC;
    if (scaled > HI)      y = HI[W-1:0];
    else if (scaled < LO) y = LO[W-1:0];
    else                  y = scaled[W-1:0];
  end
endmodule

// File: rtl/xmix_matrix.sv
module xmix_matrix
  import xmix_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic signed [W-1:0] in_l,
  input  logic signed [W-1:0] in_r,
  input  logic                coef_wr,
  input  logic [CODE_W-1:0]   coef_idx,
  output logic                out_valid,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_r
);
  localparam int PTR_W = $clog2(NUM_COEF);

  logic [PTR_W-1:0]                  wr_ptr;
  logic [PTR_W-1:0]                  wr_ptr_d;
  logic [NUM_COEF-1:0][CODE_W-1:0]   tgt_idx;
  logic [NUM_COEF-1:0][CODE_W-1:0]   cur_idx;
  logic [NUM_COEF-1:0][CODE_W-1:0]   nxt_idx;
  logic [NUM_COEF-1:0][GAIN_W-1:0]   gain;
  logic signed [W-1:0]               mix_l;
  logic signed [W-1:0]               mix_r;
  logic signed [W-1:0]               out_l_d;
  logic signed [W-1:0]               out_r_d;

  assign wr_ptr_d = coef_wr ? wr_ptr + 1'b1 : wr_ptr;

  for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
    xmix_coef_ramp #(.RST_CODE(reset_code(k))) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (coef_wr && (wr_ptr == PTR_W'(k))),
      .wr_code (coef_idx),
      .step_en (sample_valid),
      .tgt     (tgt_idx[k]),
      .cur     (cur_idx[k]),
      .nxt     (nxt_idx[k])
    );
    xmix_gain_lut u_lut (
      .code (nxt_idx[k]),
      .gain (gain[k])
    );
  end

  xmix_mix_chan #(.W(W)) u_left (
    .a(in_l), .b(in_r), .ga(gain[SLOT_LL]), .gb(gain[SLOT_RL]), .y(mix_l)
  );
  xmix_mix_chan #(.W(W)) u_right (
    .a(in_l), .b(in_r), .ga(gain[SLOT_LR]), .gb(gain[SLOT_RR]), .y(mix_r)
  );

  always_comb begin
    out_l_d = sample_valid ? mix_l : out_l;
    out_r_d = sample_valid ? mix_r : out_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      wr_ptr    <= wr_ptr_d;
      out_valid <= sample_valid;
      out_l     <= out_l_d;
      out_r     <= out_r_d;
    end
  end
endmodule

// File: rtl/xmix_matrix_chk.sv
module xmix_matrix_chk
  import xmix_pkg::*;
#(
  parameter int W = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              sample_valid,
  input logic                              coef_wr,
  input logic                              out_valid,
  input logic signed [W-1:0]               out_l,
  input logic signed [W-1:0]               out_r,
  input logic [1:0]                        wr_ptr,
  input logic [NUM_COEF-1:0][CODE_W-1:0]   tgt_idx,
  input logic [NUM_COEF-1:0][CODE_W-1:0]   cur_idx,
  input logic [NUM_COEF-1:0][CODE_W-1:0]   nxt_idx
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> out_valid); // R8
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !out_valid); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> ($stable(out_l) && $stable(out_r))); // R8
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr |=> (wr_ptr == $past(wr_ptr) + 2'd1)); // R4
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_wr |=> $stable(wr_ptr)); // R4
  AST_ALL_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && nxt_idx == {NUM_COEF{CODE_MUTE}}) |=> (out_l == '0 && out_r == '0)); // R3

  for (genvar k = 0; k < NUM_COEF; k++) begin : g_chk
    AST_RAMP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> (cur_idx[k] == $past(cur_idx[k]) ||
                        cur_idx[k] == $past(cur_idx[k]) + 8'd1 ||
                        cur_idx[k] + 8'd1 == $past(cur_idx[k]))); // R5
    AST_RAMP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && cur_idx[k] != tgt_idx[k]) |=> !$stable(cur_idx[k])); // R5
    AST_RAMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> $stable(cur_idx[k])); // R10
  end
endmodule

bind xmix_matrix xmix_matrix_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .coef_wr      (coef_wr),
  .out_valid    (out_valid),
  .out_l        (out_l),
  .out_r        (out_r),
  .wr_ptr       (wr_ptr),
  .tgt_idx      (tgt_idx),
  .cur_idx      (cur_idx),
  .nxt_idx      (nxt_idx)
);

// File: tb/xmix_matrix_bench.sv
module xmix_matrix_bench;
  localparam int W = 16;

  logic                clk;
  logic                rst_n;
  logic                sample_valid;
  logic signed [W-1:0] in_l;
  logic signed [W-1:0] in_r;
  logic                coef_wr;
  logic [7:0]          coef_idx;
  logic                out_valid;
  logic signed [W-1:0] out_l;
  logic signed [W-1:0] out_r;

  int  checks;
  int  errors;
  bit  done;

  xmix_matrix #(.W(W)) u_xmix_matrix (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .in_l(in_l), .in_r(in_r),
    .coef_wr(coef_wr), .coef_idx(coef_idx), .out_valid(out_valid),
    .out_l(out_l), .out_r(out_r)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] code);
    @(negedge clk);
    coef_wr = 1'b1; coef_idx = code;
    @(negedge clk);
    coef_wr = 1'b0;
  endtask

  task automatic wr_all(input logic [7:0] ll, input logic [7:0] lr,
                        input logic [7:0] rl, input logic [7:0] rr);
    wr(ll); wr(lr); wr(rl); wr(rr);
  endtask

  task automatic smp(input int l, input int r);
    @(negedge clk);
    sample_valid = 1'b1; in_l = W'(l); in_r = W'(r);
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) smp(0, 0);
  endtask

  task automatic t_reset;
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 out_l", int'(out_l), 0);
    chk("R9 out_r", int'(out_r), 0);
    smp(1000, -500);
    chk("R9 identity left", int'(out_l), 1000);
    chk("R9 identity right", int'(out_r), -500);
    chk("R8 valid after strobe", int'(out_valid), 1);
    @(negedge clk);
    chk("R8 valid drops", int'(out_valid), 0);
    chk("R8 out_l holds", int'(out_l), 1000);
  endtask

  task automatic t_gain_fine;
    wr_all(8'd32, 8'd64, 8'd255, 8'd0);
    settle(200);
    smp(-32768, 0);
    chk("R1 code32", int'(out_l), -16384);
    chk("R1 code64", int'(out_r), -8192);
    wr_all(8'd16, 8'd0, 8'd255, 8'd0);
    settle(70);
    smp(-32768, 0);
    chk("R1 code16", int'(out_l), -23170);
    chk("R1 code0", int'(out_r), -32768);
  endtask

  task automatic t_gain_coarse;
    wr_all(8'd80, 8'd254, 8'd255, 8'd0);
    settle(260);
    smp(-32768, 0);
    chk("R2 code80", int'(out_l), -4096);
    chk("R2 code254", int'(out_r), -2);
    wr_all(8'd80, 8'd65, 8'd255, 8'd0);
    settle(200);
    smp(-32768, 0);
    chk("R2 code65", int'(out_r), -7844);
  endtask

  task automatic t_mute;
    wr_all(8'd255, 8'd255, 8'd255, 8'd255);
    settle(260);
    smp(-32768, -32768);
    chk("R3 mute left", int'(out_l), 0);
    chk("R3 mute right", int'(out_r), 0);
    smp(12345, -777);
    chk("R3 mute left2", int'(out_l), 0);
  endtask

  task automatic t_order;
    wr_all(8'd0, 8'd32, 8'd64, 8'd255);
    settle(260);
    smp(-32768, 0);
    chk("R4 slot0 LL", int'(out_l), -32768);
    chk("R4 slot1 LR", int'(out_r), -16384);
    smp(0, -32768);
    chk("R4 slot2 RL", int'(out_l), -8192);
    chk("R4 slot3 RR", int'(out_r), 0);
  endtask

  task automatic t_ramp;
    wr_all(8'd0, 8'd255, 8'd255, 8'd0);
    settle(260);
    wr_all(8'd10, 8'd255, 8'd255, 8'd0);
    repeat (20) @(negedge clk);
    smp(-32768, 0);
    chk("R5 first step", int'(out_l), -32066);
    repeat (20) @(negedge clk);
    smp(-32768, 0);
    chk("R10 no step while idle", int'(out_l), -31379);
    settle(8);
    wr_all(8'd0, 8'd255, 8'd255, 8'd0);
    smp(-32768, 0);
    chk("R5 step down", int'(out_l), -26964);
  endtask

  task automatic t_mix;
    wr_all(8'd0, 8'd255, 8'd32, 8'd0);
    settle(300);
    smp(1000, 301);
    chk("R6 mix left", int'(out_l), 1150);
    chk("R6 mix right", int'(out_r), 301);
    smp(-1000, -301);
    chk("R6 mix left floor", int'(out_l), -1151);
    chk("R6 mix right neg", int'(out_r), -301);
  endtask

  task automatic t_sat;
    wr_all(8'd0, 8'd255, 8'd0, 8'd0);
    settle(40);
    smp(30000, 10000);
    chk("R7 clamp high", int'(out_l), 32767);
    chk("R7 right pass", int'(out_r), 10000);
    smp(-30000, -10000);
    chk("R7 clamp low", int'(out_l), -32768);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; sample_valid = 1'b0; coef_wr = 1'b0;
    coef_idx = '0; in_l = '0; in_r = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gain_fine();
    t_gain_coarse();
    t_mute();
    t_order();
    t_ramp();
    t_mix();
    t_sat();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule